// File: doc/BRIEF.md
# Snooping Cache Line Coherence Controller

This block keeps the four-state coherence status for every line of a small direct-mapped cache that shares a snooping bus with peer caches. Each cycle it can take one local request and one snooped bus event. The local request is a read, a write or an eviction. The snooped event is a read or a write seen from another cache. For each, it returns the line's next state. The local side also produces the bus command to issue and a write-back request for dirty evictions. The snoop side produces a write-back request for dirty lines that another cache wants. It also returns a copy-held indication that peers sample when deciding how to fill a read miss.

Line states are held in an array indexed by line address. The block stores no data and has no arbiter or memory model. A read miss fills clean-exclusive when the sampled other-copy input is low, and shared when that input is high. When a snoop and a local request hit the same line in one cycle, the snoop transition is applied first. The local transition is then computed from that intermediate state.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line reads as Invalid on the lookup port. The state code is Invalid=00, Shared=01, Exclusive=10, Modified=11.
- R2: A local read (req_op=01) of an Invalid line issues bus_cmd=01 (fill read). The line becomes Exclusive when other_copy_in is 0 and Shared when it is 1.
- R3: A local write (req_op=10) of an Invalid line issues bus_cmd=10 (fill for ownership) and the line becomes Modified.
- R4: A local write to an Exclusive line makes it Modified with bus_cmd=00. A local read of a Shared, Exclusive or Modified line leaves the state unchanged with bus_cmd=00.
- R5: A local write to a Shared line makes it Modified and issues bus_cmd=11 (invalidate others).
- R6: A local eviction (req_op=11) leaves the line Invalid. req_wb is 1 only when the evicted line was Modified.
- R7: A snooped read moves Exclusive and Modified to Shared. snp_wb is 1 for the Modified case. Shared and Invalid lines keep their state.
- R8: A snooped write (snp_write=1) moves every valid line to Invalid. snp_wb is 1 when the line was Modified.
- R9: copy_held_out is 1 exactly when snp_valid is 1 and the snooped line was not Invalid before the snoop.
- R10: When a snoop and a local request name the same line in one cycle, the local transition starts from the post-snoop state.
- R11: A snoop and a local request to different lines in one cycle both take effect, including two write-back flags at once.
- R12: In a two-cache read, read, write, read sequence on one line, the states become E/I, S/S, M/I and S/S. The final step writes back the dirty copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_op | input | 2 | Local request: 00 none, 01 read, 10 write, 11 evict |
| req_idx | input | IDX_W | Line index of the local request |
| other_copy_in | input | 1 | Sampled indication that a peer holds the line |
| snp_valid | input | 1 | A snooped bus event is present |
| snp_write | input | 1 | Snooped event is a write (1) or a read (0) |
| snp_idx | input | IDX_W | Line index of the snooped event |
| look_idx | input | IDX_W | Line index for state lookup |
| req_state | output | 2 | Next state of the locally requested line |
| bus_cmd | output | 2 | Bus command: 00 none, 01 read, 10 read-for-ownership, 11 invalidate |
| req_wb | output | 1 | Write-back needed for the evicted line |
| snp_state | output | 2 | Next state of the snooped line |
| snp_wb | output | 1 | Write-back needed for the snooped line |
| copy_held_out | output | 1 | This cache holds the snooped line |
| look_state | output | 2 | Stored state of the line at look_idx |

## Verification
A wrong stored state shows on the very next access to that line. A read that should hit issues a fill command instead, a write that should be silent broadcasts an invalidate, or a snoop misses a needed write-back. All of these outputs are combinational from the stored state, so the fault is visible in the same cycle as that access. The lookup port shows a wrong state one cycle after the update edge, with no further access needed. The bench runs two instances wired as peers. Each step's effect on both caches is therefore compared the cycle after it happens, and the other-copy signal is fed by real peer state.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'b00,
    ST_S = 2'b01,
    ST_E = 2'b10,
    ST_M = 2'b11
  } line_st_e;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_READ  = 2'b01,
    OP_WRITE = 2'b10,
    OP_EVICT = 2'b11
  } lop_e;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_RD   = 2'b01,
    CMD_RDX  = 2'b10,
    CMD_INV  = 2'b11
  } bcmd_e;

  typedef struct packed {
    line_st_e nxt;
    bcmd_e    cmd;
    logic     wb;
  } local_res_t;

  typedef struct packed {
    line_st_e nxt;
    logic     wb;
    logic     held;
  } snoop_res_t;

  // Local processor side transition.
  function automatic local_res_t local_step(line_st_e cur, lop_e op, logic other_copy);
    local_res_t r;
    r.nxt = cur;
    r.cmd = CMD_NONE;
    r.wb  = 1'b0;
    unique case (op)
      OP_READ: begin
        if (cur == ST_I) begin
          r.cmd = CMD_RD;
          r.nxt = other_copy ? ST_S : ST_E;
        end
      end
      OP_WRITE: begin
        if (cur == ST_I)      r.cmd = CMD_RDX;
        else if (cur == ST_S) r.cmd = CMD_INV;
        r.nxt = ST_M;
      end
      OP_EVICT: begin
        r.wb  = (cur == ST_M);
        r.nxt = ST_I;
      end
      default: ;
    endcase
    return r;
  endfunction

  // Snooped bus side transition.
  function automatic snoop_res_t snoop_step(line_st_e cur, logic valid, logic is_write);
    snoop_res_t r;
    r.nxt  = cur;
    r.wb   = 1'b0;
    r.held = 1'b0;
    if (valid) begin
      r.held = (cur != ST_I);
      r.wb   = (cur == ST_M);
      if (is_write)        r.nxt = ST_I;
      else if (cur != ST_I) r.nxt = ST_S;
    end
    return r;
  endfunction

endpackage

// File: rtl/mesi_local_fsm.sv
module mesi_local_fsm
  import mesi_pkg::*;
(
  input  line_st_e cur,
  input  lop_e     op,
  input  logic     other_copy,
  output line_st_e nxt,
  output bcmd_e    cmd,
  output logic     wb
);
  local_res_t res;

  always_comb begin
    res = local_step(cur, op, other_copy);
    nxt = res.nxt;
    cmd = res.cmd;
    wb  = res.wb;
  end
endmodule

// File: rtl/mesi_snoop_fsm.sv
module mesi_snoop_fsm
  import mesi_pkg::*;
(
  input  line_st_e cur,
  input  logic     valid,
  input  logic     is_write,
  output line_st_e nxt,
  output logic     wb,
  output logic     held
);
  snoop_res_t res;

  always_comb begin
    res  = snoop_step(cur, valid, is_write);
    nxt  = res.nxt;
    wb   = res.wb;
    held = res.held;
  end
endmodule

// File: rtl/mesi_line_array.sv
module mesi_line_array
  import mesi_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             snp_we,
  input  logic [IDX_W-1:0] snp_idx,
  input  line_st_e         snp_val,
  input  logic             req_we,
  input  logic [IDX_W-1:0] req_idx,
  input  line_st_e         req_val,
  input  logic [IDX_W-1:0] rd_snp_idx,
  output line_st_e         rd_snp,
  input  logic [IDX_W-1:0] rd_req_idx,
  output line_st_e         rd_req,
  input  logic [IDX_W-1:0] rd_look_idx,
  output line_st_e         rd_look
);
  line_st_e st [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    // The local value already folds in a same-line snoop, so it takes priority.
    always_ff @(posedge clk) begin
      if (!rst_n)                                   st[g] <= ST_I;
      else if (req_we && req_idx == IDX_W'(g))      st[g] <= req_val;
      else if (snp_we && snp_idx == IDX_W'(g))      st[g] <= snp_val;
    end
  end

  assign rd_snp  = st[rd_snp_idx];
  assign rd_req  = st[rd_req_idx];
  assign rd_look = st[rd_look_idx];

  // R11: a snoop to a line other than the request's line is stored as given.
  a_r11_snoop_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_we && !(req_we && req_idx == snp_idx) && rd_look_idx == snp_idx)
      |=> (rd_look == $past(snp_val)));
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int LINES = 16,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       req_op,
  input  logic [IDX_W-1:0] req_idx,
  input  logic             other_copy_in,
  input  logic             snp_valid,
  input  logic             snp_write,
  input  logic [IDX_W-1:0] snp_idx,
  input  logic [IDX_W-1:0] look_idx,
  output logic [1:0]       req_state,
  output logic [1:0]       bus_cmd,
  output logic             req_wb,
  output logic [1:0]       snp_state,
  output logic             snp_wb,
  output logic             copy_held_out,
  output logic [1:0]       look_state
);
  lop_e     op;
  line_st_e snp_cur, req_stored, req_base, look_cur;
  line_st_e snp_nxt, req_nxt;
  bcmd_e    cmd;
  logic     same_line;
  logic     snp_wb_w, req_wb_w, held_w;
  logic     req_active;

  assign op         = lop_e'(req_op);
  assign req_active = (op != OP_NONE);
  assign same_line  = snp_valid && req_active && (snp_idx == req_idx);

  mesi_line_array #(.LINES(LINES)) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .snp_we     (snp_valid),
    .snp_idx    (snp_idx),
    .snp_val    (snp_nxt),
    .req_we     (req_active),
    .req_idx    (req_idx),
    .req_val    (req_nxt),
    .rd_snp_idx (snp_idx),
    .rd_snp     (snp_cur),
    .rd_req_idx (req_idx),
    .rd_req     (req_stored),
    .rd_look_idx(look_idx),
    .rd_look    (look_cur)
  );

  mesi_snoop_fsm u_snoop (
    .cur     (snp_cur),
    .valid   (snp_valid),
    .is_write(snp_write),
    .nxt     (snp_nxt),
    .wb      (snp_wb_w),
    .held    (held_w)
  );

  // Snoop first: a same-line local request starts from the post-snoop state.
  assign req_base = same_line ? snp_nxt : req_stored;

  mesi_local_fsm u_local (
    .cur       (req_base),
    .op        (op),
    .other_copy(other_copy_in),
    .nxt       (req_nxt),
    .cmd       (cmd),
    .wb        (req_wb_w)
  );

  assign req_state     = req_nxt;
  assign bus_cmd       = cmd;
  assign req_wb        = req_wb_w;
  assign snp_state     = snp_nxt;
  assign snp_wb        = snp_wb_w;
  assign copy_held_out = held_w;
  assign look_state    = look_cur;

  a_r3_write_owns: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE) |-> (req_nxt == ST_M));

  a_r6_evict_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_EVICT) |-> (req_nxt == ST_I));

  a_r6_wb_on_evict_only: assert property (@(posedge clk) disable iff (!rst_n)
    req_wb |-> (op == OP_EVICT));

  a_r5_inv_from_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_INV) |-> (op == OP_WRITE && req_base == ST_S));

  a_r2_fill_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD) |-> (op == OP_READ && (req_nxt == ST_S || req_nxt == ST_E)));

  a_r7_snoop_drops_ownership: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> (snp_nxt == ST_I || snp_nxt == ST_S));

  a_r9_held_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    held_w |-> snp_valid);

  a_r4_write_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_WRITE && look_idx == req_idx) |=> (look_cur == ST_M));
endmodule

// File: tb/mesi_line_ctrl_tb_top.sv
module mesi_line_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int LINES = 16;
  localparam int IDX_W = $clog2(LINES);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // cache A (dut_i) and cache B (peer_i)
  logic [1:0] a_op, b_op;
  logic [IDX_W-1:0] a_idx, b_idx, a_sidx, b_sidx, a_look, b_look;
  logic a_sv, a_sw, b_sv, b_sw, tb_sh, sh_from_peer;
  logic [1:0] a_rs, a_cmd, a_ss, a_ls, b_rs, b_cmd, b_ss, b_ls;
  logic a_rwb, a_swb, a_held, b_rwb, b_swb, b_held;
  logic a_oc;

  assign a_oc = sh_from_peer ? b_held : tb_sh;

  mesi_line_ctrl #(.LINES(LINES)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_op(a_op), .req_idx(a_idx), .other_copy_in(a_oc),
    .snp_valid(a_sv), .snp_write(a_sw), .snp_idx(a_sidx), .look_idx(a_look),
    .req_state(a_rs), .bus_cmd(a_cmd), .req_wb(a_rwb), .snp_state(a_ss),
    .snp_wb(a_swb), .copy_held_out(a_held), .look_state(a_ls));

  mesi_line_ctrl #(.LINES(LINES)) peer_i (
    .clk(clk), .rst_n(rst_n), .req_op(b_op), .req_idx(b_idx), .other_copy_in(a_held),
    .snp_valid(b_sv), .snp_write(b_sw), .snp_idx(b_sidx), .look_idx(b_look),
    .req_state(b_rs), .bus_cmd(b_cmd), .req_wb(b_rwb), .snp_state(b_ss),
    .snp_wb(b_swb), .copy_held_out(b_held), .look_state(b_ls));

  int ma [LINES];
  int mb [LINES];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // behavioural models, state codes I=0 S=1 E=2 M=3
  function automatic void snp_model(input int s, input bit sv, input bit sw,
                                    output int ns, output bit wb, output bit held);
    ns = s; wb = 0; held = 0;
    if (sv) begin
      held = (s != 0);
      wb = (s == 3);
      if (sw) ns = 0;
      else if (s != 0) ns = 1;
    end
  endfunction

  function automatic void loc_model(input int s, input int op, input bit oc,
                                    output int ns, output int cmd, output bit wb);
    ns = s; cmd = 0; wb = 0;
    case (op)
      1: if (s == 0) begin cmd = 1; ns = oc ? 1 : 2; end
      2: begin
        if (s == 0) cmd = 2;
        else if (s == 1) cmd = 3;
        ns = 3;
      end
      3: begin wb = (s == 3); ns = 0; end
      default: ;
    endcase
  endfunction

  task automatic cyc(input int aop, input int aidx, input bit asv, input bit asw, input int asidx,
                     input bit ash, input bit peer, input int bop, input int bidx,
                     input bit bsv, input bit bsw, input int bsidx, input string tag);
    int asn, bsn, arn, brn, acmd, bcmd, abase, bbase;
    bit aswb, bswb, aheld, bheld, arwb, brwb, aoc;
    @(negedge clk);
    a_op = 2'(aop); a_idx = IDX_W'(aidx); a_sv = asv; a_sw = asw; a_sidx = IDX_W'(asidx);
    tb_sh = ash; sh_from_peer = peer;
    b_op = 2'(bop); b_idx = IDX_W'(bidx); b_sv = bsv; b_sw = bsw; b_sidx = IDX_W'(bsidx);
    #1;
    snp_model(ma[asidx], asv, asw, asn, aswb, aheld);
    snp_model(mb[bsidx], bsv, bsw, bsn, bswb, bheld);
    abase = (asv && aop != 0 && asidx == aidx) ? asn : ma[aidx];
    bbase = (bsv && bop != 0 && bsidx == bidx) ? bsn : mb[bidx];
    aoc = peer ? bheld : ash;
    loc_model(abase, aop, aoc, arn, acmd, arwb);
    loc_model(bbase, bop, aheld, brn, bcmd, brwb);
    chk(tag, "A req_state", int'(a_rs), arn);
    chk(tag, "A bus_cmd", int'(a_cmd), acmd);
    chk(tag, "A req_wb", int'(a_rwb), int'(arwb));
    chk(tag, "A snp_state", int'(a_ss), asn);
    chk(tag, "A snp_wb", int'(a_swb), int'(aswb));
    chk(tag, "A copy_held", int'(a_held), int'(aheld));
    chk(tag, "B req_state", int'(b_rs), brn);
    chk(tag, "B bus_cmd", int'(b_cmd), bcmd);
    chk(tag, "B snp_wb", int'(b_swb), int'(bswb));
    chk(tag, "B copy_held", int'(b_held), int'(bheld));
    @(posedge clk);
    if (asv) ma[asidx] = asn;
    if (aop != 0) ma[aidx] = arn;
    if (bsv) mb[bsidx] = bsn;
    if (bop != 0) mb[bidx] = brn;
    #1;
    a_op = 0; a_sv = 0; b_op = 0; b_sv = 0;
    a_look = IDX_W'(aop != 0 ? aidx : asidx);
    b_look = IDX_W'(bop != 0 ? bidx : bsidx);
    #1;
    chk(tag, "A stored", int'(a_ls), ma[int'(a_look)]);
    chk(tag, "B stored", int'(b_ls), mb[int'(b_look)]);
  endtask

  // one cache issues a request; the other sees the bus traffic it implies
  task automatic bus_op(input bit on_b, input int op, input int idx, input string tag);
    int ns, cmd, sn; bit wb, swb, held, sv, sw;
    snp_model(on_b ? ma[idx] : mb[idx], 1'b1, 1'b0, sn, swb, held);
    loc_model(on_b ? mb[idx] : ma[idx], op, held, ns, cmd, wb);
    sv = (cmd != 0);
    sw = (cmd >= 2);
    if (on_b) cyc(0, idx, sv, sw, idx, 0, 1, op, idx, 0, 0, idx, tag);
    else      cyc(op, idx, 0, 0, idx, 0, 1, 0, idx, sv, sw, idx, tag);
  endtask

  task automatic raw(input int op, input int idx, input bit sv, input bit sw,
                     input int sidx, input bit sh, input string tag);
    cyc(op, idx, sv, sw, sidx, sh, 0, 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) begin ma[i] = 0; mb[i] = 0; end
    a_op = 0; a_idx = 0; a_sv = 0; a_sw = 0; a_sidx = 0; a_look = 0; tb_sh = 0; sh_from_peer = 0;
    b_op = 0; b_idx = 0; b_sv = 0; b_sw = 0; b_sidx = 0; b_look = 0;
    repeat (3) @(posedge clk);
    #1;
    for (int i = 0; i < LINES; i++) begin
      a_look = IDX_W'(i); #1;
      chk("R1", "reset state", int'(a_ls), 0);
    end
    @(negedge clk) rst_n = 1'b1;

    // R12 two-core sequence on line 5 (also R2, R5, R7)
    bus_op(0, 1, 5, "R12 A read E/I");
    chk("R12", "B line5", int'(b_ls), 0);
    bus_op(1, 1, 5, "R12 B read S/S");
    a_look = 5; #1; chk("R12", "A line5 shared", int'(a_ls), 1);
    bus_op(0, 2, 5, "R12 A write M/I");
    b_look = 5; #1; chk("R12", "B line5 invalid", int'(b_ls), 0);
    bus_op(1, 1, 5, "R12 B read S/S wb");
    a_look = 5; #1; chk("R12", "A line5 after wb", int'(a_ls), 1);

    // R2 fills
    raw(1, 1, 0, 0, 0, 0, "R2 fill exclusive");
    raw(1, 2, 0, 0, 0, 1, "R2 fill shared");
    // R4 read hits and silent upgrade
    raw(1, 1, 0, 0, 0, 0, "R4 read hit E");
    raw(1, 2, 0, 0, 0, 0, "R4 read hit S");
    raw(2, 1, 0, 0, 0, 0, "R4 write E to M");
    raw(1, 1, 0, 0, 0, 0, "R4 read hit M");
    // R5 upgrade from shared
    raw(2, 2, 0, 0, 0, 0, "R5 write S invalidate");
    // R3 write miss
    raw(2, 3, 0, 0, 0, 0, "R3 write miss");
    // R6 evictions
    raw(3, 3, 0, 0, 0, 0, "R6 evict M wb");
    raw(3, 0, 0, 0, 0, 0, "R6 evict I");
    raw(1, 4, 0, 0, 0, 1, "R2 fill shared 4");
    raw(3, 4, 0, 0, 0, 0, "R6 evict S");
    raw(1, 4, 0, 0, 0, 0, "R2 fill exclusive 4");
    raw(3, 4, 0, 0, 0, 0, "R6 evict E");
    // R7 / R9 snooped reads
    raw(1, 6, 0, 0, 0, 0, "R7 setup E");
    raw(0, 0, 1, 0, 6, 0, "R7 snoop read E");
    raw(0, 0, 1, 0, 6, 0, "R7 snoop read S");
    raw(0, 0, 1, 0, 1, 0, "R7 snoop read M wb");
    raw(0, 0, 1, 0, 9, 0, "R9 snoop read I no copy");
    // R8 snooped writes
    raw(0, 0, 1, 1, 6, 0, "R8 snoop write S");
    raw(2, 7, 0, 0, 0, 0, "R8 setup M");
    raw(0, 0, 1, 1, 7, 0, "R8 snoop write M wb");
    raw(1, 8, 0, 0, 0, 0, "R8 setup E");
    raw(0, 0, 1, 1, 8, 0, "R8 snoop write E");
    // R10 same-line collision
    raw(1, 10, 0, 0, 0, 0, "R10 setup E");
    raw(1, 10, 1, 1, 10, 1, "R10 snoop write then read refills");
    raw(2, 10, 1, 0, 10, 0, "R10 snoop read then write invalidates");
    raw(3, 10, 1, 0, 10, 0, "R10 snoop wb then evict clean");
    // R11 different lines in one cycle
    raw(2, 11, 0, 0, 0, 0, "R11 setup M 11");
    raw(2, 12, 0, 0, 0, 0, "R11 setup M 12");
    raw(3, 12, 1, 0, 11, 0, "R11 two write-backs");
    a_look = 11; #1; chk("R11", "line11 shared", int'(a_ls), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule